// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one read or write machine cycle at a time over a shared address/data bus for a 16-bit processor with a 20-bit address space. A cycle steps through the clock states T1, T2, T3, any number of TW wait states, and then T4. In T1 the low bus lines carry the low address and the upper lines carry the high address, and an address-latch strobe lets external latches hold the address. From T2 onward the low lines carry data and the upper lines carry a status code.

The core side issues a request while the sequencer reports idle: address, segment code, memory/IO flag, write flag, write data and the current interrupt-enable state. The sequencer pulses `done` in T4 and presents read data on `rd_data`. Two input flags stand in for the external arbitration logic. Hold acknowledge floats every bus line and blocks new cycles. Interrupt acknowledge floats the low sixteen lines.

Top module: `bus_cycle_seq`

## Requirements
- R1: After a synchronous reset `idle` is 1, and `ale`, `done`, `bus_ad_oe`, `bus_hi_oe` and `rd_data` are 0.
- R2: When `idle`, `req_valid` and not `hold_ack` hold at a rising edge, the next cycle is T1. In T1 `ale` is 1 for exactly one cycle, `bus_ad_oe` is 1 and `bus_ad_out` equals address bits 15..0.
- R3: In T1 `bus_hi_out` carries address bits 19..16 for a memory request (`req_io`=0) and 0000 for an I/O request (`req_io`=1), with `bus_hi_oe` at 1.
- R4: From T2 through T4, including every TW, `bus_hi_out` is {bit3 = 0, bit2 = captured interrupt enable, bits1..0 = segment code}. The segment code is 00 extra, 01 stack, 10 code or none, and 11 data. Bit 3 is never 1 outside T1.
- R5: For a write (`req_wr`=1), `bus_ad_oe` is 1 and `bus_ad_out` equals the write data from T2 through T4.
- R6: For a read, `bus_ad_oe` is 0 from T2 through T4. `rd_data` takes `bus_ad_in` at the rising edge that ends T3 or the last TW, and holds it otherwise.
- R7: `ready` is sampled at the end of T3 and of each TW. Low inserts another TW and high advances to T4, so a cycle lasts 4 + (wait count) clocks from T1 to T4 inclusive.
- R8: `done` is 1 only in T4, for one cycle, and the sequencer is idle in the cycle after.
- R9: While `hold_ack` is 1, `bus_ad_oe` and `bus_hi_oe` are 0 in the same cycle, and no request is accepted from idle.
- R10: While `inta_cycle` is 1, `bus_ad_oe` is 0 while `bus_hi_oe` keeps its normal value.
- R11: `req_valid` raised while a cycle is running has no effect: no further T1 (`ale`) follows T4 unless a request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request a machine cycle (taken only while idle) |
| req_addr | input | 20 | Cycle address |
| req_seg | input | 2 | Segment code for status bits 1..0 |
| req_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| int_en | input | 1 | Interrupt enable, captured into status bit 2 |
| hold_ack | input | 1 | Bus granted away: float all lines, block new cycles |
| inta_cycle | input | 1 | Interrupt acknowledge: float low lines |
| ready | input | 1 | Slave ready, sampled in T3/TW |
| bus_ad_in | input | 16 | Low bus lines as seen from the pins |
| bus_ad_out | output | 16 | Low bus drive value |
| bus_ad_oe | output | 1 | Low bus output enable |
| bus_hi_out | output | 4 | Upper bus drive value (address or status) |
| bus_hi_oe | output | 1 | Upper bus output enable |
| ale | output | 1 | Address latch strobe (T1) |
| rd_data | output | 16 | Last captured read data |
| done | output | 1 | Cycle complete (T4) |
| idle | output | 1 | Sequencer can accept a request |

## Verification
Two functions can coincide. A float request (hold or interrupt acknowledge) can arrive while the sequencer is driving, and a request from the core can arrive while a cycle is already running. The bench raises `hold_ack` and `inta_cycle` in the middle of write cycles and during idle requests, and it pulses `req_valid` during T2. A behavioural cycle model compares every output, enable and captured value on every clock. It confirms that the enables drop in the same cycle as the flag, that the sequence itself continues, and that a request made while busy never starts a second T1.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_t;

  localparam logic [1:0] SEG_EXTRA = 2'b00;
  localparam logic [1:0] SEG_STACK = 2'b01;
  localparam logic [1:0] SEG_CODE  = 2'b10;
  localparam logic [1:0] SEG_DATA  = 2'b11;
endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   ready,
  output phase_t phase
);
  phase_t nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (start) nxt = PH_T1;
      PH_T1:   nxt = PH_T2;
      PH_T2:   nxt = PH_T3;
      PH_T3,
      PH_TW:   nxt = ready ? PH_T4 : PH_TW;
      PH_T4:   nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= nxt;
  end
endmodule

// File: rtl/bcs_req_reg.sv
module bcs_req_reg #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [1:0]        seg_in,
  input  logic              io_in,
  input  logic              wr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              ie_in,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [1:0]        seg_q,
  output logic              io_q,
  output logic              wr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              ie_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      seg_q   <= '0;
      io_q    <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      ie_q    <= 1'b0;
    end else if (load) begin
      addr_q  <= addr_in;
      seg_q   <= seg_in;
      io_q    <= io_in;
      wr_q    <= wr_in;
      wdata_q <= wdata_in;
      ie_q    <= ie_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (capture) rdata_q <= bus_in;
  end
endmodule

// File: rtl/bcs_pin_drv.sv
module bcs_pin_drv
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  phase_t            phase,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [1:0]        seg_q,
  input  logic              io_q,
  input  logic              wr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              ie_q,
  input  logic              hold_ack,
  input  logic              inta_cycle,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   hi_out,
  output logic              hi_oe,
  output logic              ale
);
  logic in_t1, in_cycle, data_phase;
  logic [HI_W-1:0] hi_addr, hi_stat;

  assign in_t1      = (phase == PH_T1);
  assign in_cycle   = (phase != PH_IDLE);
  assign data_phase = in_cycle && !in_t1;

  // top status bit (S6 position) stays low; extra upper lines pad with zero
  assign hi_stat = {{(HI_W-2){1'b0}}, seg_q} | (HI_W'(ie_q) << 2);
  assign hi_addr = io_q ? '0 : addr_q[ADDR_W-1:DATA_W];

  assign ale    = in_t1;
  assign ad_out = in_t1 ? addr_q[DATA_W-1:0] : wdata_q;
  assign ad_oe  = !hold_ack && !inta_cycle && (in_t1 || (data_phase && wr_q));
  assign hi_out = in_t1 ? hi_addr : hi_stat;
  assign hi_oe  = !hold_ack && in_cycle;
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_seg,
  input  logic              req_io,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              int_en,
  input  logic              hold_ack,
  input  logic              inta_cycle,
  input  logic              ready,
  input  logic [DATA_W-1:0] bus_ad_in,
  output logic [DATA_W-1:0] bus_ad_out,
  output logic              bus_ad_oe,
  output logic [HI_W-1:0]   bus_hi_out,
  output logic              bus_hi_oe,
  output logic              ale,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              idle
);
  phase_t            phase;
  logic              start, capture;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        seg_q;
  logic              io_q, wr_q, ie_q;
  logic [DATA_W-1:0] wdata_q;

  assign idle    = (phase == PH_IDLE);
  assign done    = (phase == PH_T4);
  assign start   = idle && req_valid && !hold_ack;
  assign capture = (phase == PH_T3 || phase == PH_TW) && ready && !wr_q;

  bcs_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .ready(ready), .phase(phase)
  );

  bcs_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst(rst), .load(start),
    .addr_in(req_addr), .seg_in(req_seg), .io_in(req_io), .wr_in(req_wr),
    .wdata_in(req_wdata), .ie_in(int_en),
    .capture(capture), .bus_in(bus_ad_in),
    .addr_q(addr_q), .seg_q(seg_q), .io_q(io_q), .wr_q(wr_q),
    .wdata_q(wdata_q), .ie_q(ie_q), .rdata_q(rd_data)
  );

  bcs_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .phase(phase), .addr_q(addr_q), .seg_q(seg_q), .io_q(io_q),
    .wr_q(wr_q), .wdata_q(wdata_q), .ie_q(ie_q),
    .hold_ack(hold_ack), .inta_cycle(inta_cycle),
    .ad_out(bus_ad_out), .ad_oe(bus_ad_oe),
    .hi_out(bus_hi_out), .hi_oe(bus_hi_oe), .ale(ale)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
#(
  parameter int HI_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            hold_ack,
  input logic            inta_cycle,
  input logic            ready,
  input logic            ale,
  input logic            done,
  input logic            idle,
  input logic            bus_ad_oe,
  input logic            bus_hi_oe,
  input logic [HI_W-1:0] bus_hi_out,
  input logic [2:0]      phase_q
);
  logic waiting;
  assign waiting = (phase_q == PH_T3) || (phase_q == PH_TW);

  AST_START_T1: assert property (@(posedge clk) disable iff (rst)
    (idle && req_valid && !hold_ack) |=> ale);                    // R2
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ale |=> (!ale && !idle));                                     // R2
  AST_S6_LOW: assert property (@(posedge clk) disable iff (rst)
    (bus_hi_oe && !ale) |-> !bus_hi_out[HI_W-1]);                 // R4
  AST_WAIT_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    (waiting && !ready) |=> !done);                               // R7
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |=> (idle && !done));                                    // R8
  AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> (!bus_ad_oe && !bus_hi_oe));                     // R9
  AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (rst)
    (idle && hold_ack) |=> idle);                                 // R9
  AST_INTA_FLOAT: assert property (@(posedge clk) disable iff (rst)
    inta_cycle |-> !bus_ad_oe);                                   // R10
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (!idle && !done) |=> !ale);                                   // R11
endmodule

bind bus_cycle_seq bcs_checker #(.HI_W(HI_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .hold_ack(hold_ack),
  .inta_cycle(inta_cycle), .ready(ready), .ale(ale), .done(done),
  .idle(idle), .bus_ad_oe(bus_ad_oe), .bus_hi_oe(bus_hi_oe),
  .bus_hi_out(bus_hi_out), .phase_q(phase)
);

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_io = 0, req_wr = 0, int_en = 0;
  logic        hold_ack = 0, inta_cycle = 0, ready = 1;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_seg = '0;
  logic [15:0] req_wdata = '0, bus_ad_in = '0;
  logic [15:0] bus_ad_out, rd_data;
  logic [3:0]  bus_hi_out;
  logic        bus_ad_oe, bus_hi_oe, ale, done, idle;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bus_cycle_seq i_bus_cycle_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_seg(req_seg), .req_io(req_io), .req_wr(req_wr),
    .req_wdata(req_wdata), .int_en(int_en), .hold_ack(hold_ack),
    .inta_cycle(inta_cycle), .ready(ready), .bus_ad_in(bus_ad_in),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_hi_out(bus_hi_out), .bus_hi_oe(bus_hi_oe), .ale(ale),
    .rd_data(rd_data), .done(done), .idle(idle)
  );

  // behavioural model: 0 idle, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4
  int          mph = 0;
  logic [19:0] ma;
  logic [1:0]  mseg;
  logic        mio, mwr, mie;
  logic [15:0] mwd, mrd;
  int          len = 0;
  int          exp_waits = 0;

  always @(posedge clk) begin
    if (rst) begin
      mph = 0; mrd = '0;
    end else begin
      case (mph)
        0: if (req_valid && !hold_ack) begin
             ma = req_addr; mseg = req_seg; mio = req_io; mwr = req_wr;
             mwd = req_wdata; mie = int_en; mph = 1;
           end
        1: mph = 2;
        2: mph = 3;
        3, 4: if (ready) begin
                if (!mwr) mrd = bus_ad_in;
                mph = 5;
              end else mph = 4;
        default: mph = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic e_adoe, e_hioe;
    logic [15:0] e_ad;
    logic [3:0]  e_hi;
    e_hioe = (mph != 0) && !hold_ack;
    e_adoe = !hold_ack && !inta_cycle && (mph == 1 || (mph >= 2 && mwr));
    e_ad   = (mph == 1) ? ma[15:0] : mwd;
    e_hi   = (mph == 1) ? (mio ? 4'h0 : ma[19:16]) : {1'b0, mie, mseg};
    chk(idle == (mph == 0), "R1/R11 idle", idle, mph == 0);
    chk(ale == (mph == 1), "R2 ale", ale, mph == 1);
    chk(done == (mph == 5), "R8 done", done, mph == 5);
    chk(bus_hi_oe == e_hioe, "R9 hi_oe", bus_hi_oe, e_hioe);
    chk(bus_ad_oe == e_adoe, "R5/R6/R10 ad_oe", bus_ad_oe, e_adoe);
    if (e_adoe) chk(bus_ad_out == e_ad, "R2/R5 ad_out", bus_ad_out, e_ad);
    if (e_hioe) chk(bus_hi_out == e_hi, "R3/R4 hi_out", bus_hi_out, e_hi);
    chk(rd_data == mrd, "R6 rd_data", rd_data, mrd);
    if (ale) len = 1; else if (mph != 0) len++;
    if (done && !rst) chk(len == 4 + exp_waits, "R7 cycle length", len, 4 + exp_waits);
  end

  task automatic step();
    @(posedge clk); #3;
  endtask

  task automatic run_cycle(input logic [19:0] a, input logic [1:0] s,
                           input bit io, input bit wr, input logic [15:0] wd,
                           input bit ie, input int waits, input logic [15:0] din,
                           input bit poke, input bit hold_mid, input bit inta_mid);
    exp_waits = waits;
    req_addr = a; req_seg = s; req_io = io; req_wr = wr; req_wdata = wd;
    int_en = ie; bus_ad_in = din; req_valid = 1; ready = (waits == 0);
    step();                                    // T1
    req_valid = 0; req_addr = ~a; req_wdata = ~wd; int_en = ~ie;
    step();                                    // T2
    if (poke) req_valid = 1;                   // R11 busy request
    hold_ack = hold_mid; inta_cycle = inta_mid;
    step();                                    // T3
    req_valid = 0; hold_ack = 0;
    for (int i = 0; i < waits; i++) step();
    ready = 1;
    step();                                    // T4
    inta_cycle = 0;
    step();                                    // idle
    ready = 1;
    step();
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    // R2 R3 R4 R6: memory read, no wait, stack segment
    run_cycle(20'hA5C31, 2'b01, 0, 0, 16'h0, 1, 0, 16'hBEEF, 0, 0, 0);
    // R5 R3: I/O write, one wait, data segment
    run_cycle(20'hF1234, 2'b11, 1, 1, 16'h5A5A, 0, 1, 16'h0, 0, 0, 0);
    // R7 R6: memory read, three waits, extra segment
    run_cycle(20'h7FFFF, 2'b00, 0, 0, 16'h0, 0, 3, 16'h1357, 0, 0, 0);
    // R11: request raised while busy
    run_cycle(20'h0ABCD, 2'b10, 0, 1, 16'hC0DE, 1, 2, 16'h0, 1, 0, 0);
    // R9: hold raised mid write cycle
    run_cycle(20'h80001, 2'b10, 0, 1, 16'h9999, 1, 0, 16'h0, 0, 1, 0);
    // R10: interrupt acknowledge during write
    run_cycle(20'h33333, 2'b01, 0, 1, 16'h7777, 0, 2, 16'h0, 0, 0, 1);
    // R9: request while hold is active is not accepted
    hold_ack = 1; req_valid = 1; req_wr = 0;
    repeat (4) step();
    chk(idle == 1, "R9 no start under hold", idle, 1);
    req_valid = 0; hold_ack = 0;
    step();
    // R6: read with IO flag, long wait
    run_cycle(20'h12345, 2'b11, 1, 0, 16'h0, 1, 5, 16'hFACE, 0, 0, 0);
    // R1: reset in the middle of a cycle
    req_valid = 1; req_wr = 1; ready = 0;
    step(); req_valid = 0; step();
    rst = 1; step();
    chk(idle == 1 && rd_data == 0, "R1 reset mid-cycle", {idle, rd_data}, 17'h10000);
    rst = 0; ready = 1;
    repeat (3) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule